// File: doc/BRIEF.md
# Tone-Gated Satellite Control Message Transmitter

This block sends a short control message to satellite reception equipment such as a dish switch or a positioner. It does this by switching a 22 kHz carrier on and off. The host presents up to `MAX_BYTES` message bytes, a byte count and a trailing-burst choice, then pulses `start`.

The block first keeps the line quiet for a lead-in period. It then sends every byte most significant bit first, and each byte ends with an odd-parity bit. Every bit is one tone interval followed by one silent interval, and the bit value sets which of the two intervals is the short one. After the last byte the block keeps a silent gap. It can then send one of two trailing commands, an unmodulated tone burst or an all-ones data byte, followed by a closing silence. At the end it pulses `done`.

While no message is in flight, a continuous-tone input drives the gate directly. All timing is counted in ticks of a prescaled clock. A free-running divider makes the carrier, and the gate masks it onto `tone_out`.

Top module: `sat_tone_msg_tx`

## Requirements
- R1: After a synchronous active-high reset, `busy`, `done`, `gate_out` and `tone_out` are all low, provided `cont_tone` is low.
- R2: While idle, `gate_out` equals `cont_tone`. While `busy`, `cont_tone` has no effect on `gate_out`.
- R3: A transmission begins with `gate_out` low for `T_LEAD` ticks.
- R4: A logic 1 bit is `T_SHORT` ticks of gate on followed by `T_LONG` ticks of gate off. A logic 0 bit is `T_LONG` ticks on followed by `T_SHORT` ticks off.
- R5: The bytes are sent in this order: `msg_data[7:0]` first, then `msg_data[15:8]`, and so on. Each byte goes out bit 7 first. The number of bytes is `msg_len`, limited to `MAX_BYTES`. `msg_data`, `msg_len` and `burst_sel` are captured at `start`.
- R6: After the eight data bits of each byte, one parity bit is sent. Its value is 1 XOR all eight data bits.
- R7: After the last message byte the gate is held off for `T_GAP` ticks.
- R8: `burst_sel` selects the trailing command: 2'b01 sends the gate on continuously for `T_BURST` ticks; 2'b10 sends the byte 0xFF, which includes its parity bit of value 1.
- R9: After either trailing command the gate stays off for `T_TAIL` ticks. With `burst_sel` 2'b00 or 2'b11 the block skips both the burst and this silence and completes at the end of the gap.
- R10: When `msg_len` is zero, the lead-in is followed directly by the gap. The two form a single silence of `T_LEAD+T_GAP` ticks.
- R11: `busy` rises on the clock edge that accepts `start` and falls on the edge that ends the last phase. `done` is high for exactly the one cycle after `busy` falls. A `start` that arrives while `busy` is high is ignored.
- R12: `tone_out` is a free-running square wave that toggles every `CLK_HZ/(2*TONE_HZ)` cycles, ANDed with `gate_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a transmission (accepted only when idle) |
| msg_data | input | 8*MAX_BYTES | Message bytes, byte 0 in bits 7:0 |
| msg_len | input | LEN_W | Number of bytes to send |
| burst_sel | input | 2 | 00/11 none, 01 tone burst, 10 data burst |
| cont_tone | input | 1 | Steady tone request while idle |
| busy | output | 1 | Transmission in progress |
| done | output | 1 | One-cycle completion pulse |
| gate_out | output | 1 | Tone envelope |
| tone_out | output | 1 | Carrier masked by the envelope |

## Verification
The hardest case to reach from the ports is a second `start` that arrives in the middle of a message. It comes together with new data, a new length, a new burst choice and a raised continuous-tone request, and none of these may leak into the envelope. The bench injects exactly this disturbance partway through selected runs. It then compares the complete envelope, as a list of on/off run lengths, against the list it computed from the captured inputs. A full sweep of all 256 single-byte values exercises every parity outcome and every bit pattern. Runs with zero length, with lengths above the limit and with every burst choice cover the silences that merge together.

// File: rtl/sat_tone_msg_tx.sv
module sat_tone_msg_tx #(
  parameter int CLK_HZ    = 48_000_000,
  parameter int TICK_HZ   = 1_000_000,
  parameter int TONE_HZ   = 22_000,
  parameter int MAX_BYTES = 4,
  parameter int LEN_W     = 3,
  parameter int T_SHORT   = 500,
  parameter int T_LONG    = 1000,
  parameter int T_LEAD    = 16000,
  parameter int T_GAP     = 16000,
  parameter int T_BURST   = 12500,
  parameter int T_TAIL    = 20000
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [8*MAX_BYTES-1:0] msg_data,
  input  logic [LEN_W-1:0]       msg_len,
  input  logic [1:0]             burst_sel,
  input  logic                   cont_tone,
  output logic                   busy,
  output logic                   done,
  output logic                   gate_out,
  output logic                   tone_out
);

  localparam int TICK_DIV = CLK_HZ / TICK_HZ;
  localparam int HALF_DIV = CLK_HZ / (2 * TONE_HZ);
  localparam int M1 = (T_SHORT > T_LONG) ? T_SHORT : T_LONG;
  localparam int M2 = (T_LEAD > T_GAP) ? T_LEAD : T_GAP;
  localparam int M3 = (T_BURST > T_TAIL) ? T_BURST : T_TAIL;
  localparam int M4 = (M1 > M2) ? M1 : M2;
  localparam int TMAX = (M3 > M4) ? M3 : M4;
  localparam int CW = $clog2(TMAX + 1);
  localparam int PW = $clog2(TICK_DIV + 1);
  localparam int HW = $clog2(HALF_DIV + 1);

  localparam logic [CW-1:0] L_SHORT = CW'(T_SHORT - 1);
  localparam logic [CW-1:0] L_LONG  = CW'(T_LONG - 1);
  localparam logic [CW-1:0] L_LEAD  = CW'(T_LEAD - 1);
  localparam logic [CW-1:0] L_GAP   = CW'(T_GAP - 1);
  localparam logic [CW-1:0] L_BURST = CW'(T_BURST - 1);
  localparam logic [CW-1:0] L_TAIL  = CW'(T_TAIL - 1);
  localparam logic [LEN_W-1:0] MAXB = LEN_W'(MAX_BYTES);

  typedef enum logic [2:0] {
    S_IDLE, S_LEAD, S_ON, S_OFF, S_GAP, S_BURST, S_TAIL
  } state_t;

  state_t                 state;
  logic [8*MAX_BYTES-1:0] data_q;
  logic [LEN_W-1:0]       left_q;
  logic [7:0]             byte_q;
  logic                   par_q;
  logic [3:0]             bit_q;
  logic [1:0]             mode_q;
  logic                   in_burst_q;
  logic [CW-1:0]          cnt_q;
  logic [PW-1:0]          pre_q;
  logic                   done_q;
  logic [HW-1:0]          car_cnt;
  logic                   car_q;

  function automatic logic [CW-1:0] on_len(input logic b);
    return b ? L_SHORT : L_LONG;
  endfunction

  function automatic logic [CW-1:0] off_len(input logic b);
    return b ? L_LONG : L_SHORT;
  endfunction

  wire tick     = (pre_q == PW'(TICK_DIV - 1));
  wire cur_bit  = bit_q[3] ? par_q : byte_q[7];
  wire next_bit = (bit_q == 4'd7) ? par_q : byte_q[6];
  wire [LEN_W-1:0] n_bytes = (msg_len > MAXB) ? MAXB : msg_len;

  assign busy     = (state != S_IDLE);
  assign done     = done_q;
  assign gate_out = (state == S_IDLE) ? cont_tone
                  : (state == S_ON || state == S_BURST);
  assign tone_out = gate_out & car_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      car_cnt <= '0;
      car_q   <= 1'b0;
    end else if (car_cnt == HW'(HALF_DIV - 1)) begin
      car_cnt <= '0;
      car_q   <= ~car_q;
    end else begin
      car_cnt <= car_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      data_q     <= '0;
      left_q     <= '0;
      byte_q     <= '0;
      par_q      <= 1'b0;
      bit_q      <= '0;
      mode_q     <= '0;
      in_burst_q <= 1'b0;
      cnt_q      <= '0;
      pre_q      <= '0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      pre_q  <= (state == S_IDLE || tick) ? '0 : pre_q + 1'b1;
      if (state == S_IDLE) begin
        if (start) begin
          state      <= S_LEAD;
          data_q     <= msg_data;
          left_q     <= n_bytes;
          mode_q     <= burst_sel;
          in_burst_q <= 1'b0;
          cnt_q      <= L_LEAD;
        end
      end else if (tick) begin
        if (cnt_q != '0) begin
          cnt_q <= cnt_q - 1'b1;
        end else begin
          case (state)
            S_LEAD, S_OFF: begin
              if (state == S_OFF && !bit_q[3]) begin
                bit_q  <= bit_q + 1'b1;
                byte_q <= {byte_q[6:0], 1'b0};
                state  <= S_ON;
                cnt_q  <= on_len(next_bit);
              end else if (in_burst_q) begin
                state <= S_TAIL;
                cnt_q <= L_TAIL;
              end else if (left_q != '0) begin
                byte_q <= data_q[7:0];
                par_q  <= ~(^data_q[7:0]);
                data_q <= data_q >> 8;
                left_q <= left_q - 1'b1;
                bit_q  <= '0;
                state  <= S_ON;
                cnt_q  <= on_len(data_q[7]);
              end else begin
                state <= S_GAP;
                cnt_q <= L_GAP;
              end
            end
            S_ON: begin
              state <= S_OFF;
              cnt_q <= off_len(cur_bit);
            end
            S_GAP: begin
              if (mode_q == 2'b01) begin
                state <= S_BURST;
                cnt_q <= L_BURST;
              end else if (mode_q == 2'b10) begin
                byte_q     <= 8'hFF;
                par_q      <= 1'b1;
                bit_q      <= '0;
                in_burst_q <= 1'b1;
                state      <= S_ON;
                cnt_q      <= L_SHORT;
              end else begin
                state  <= S_IDLE;
                done_q <= 1'b1;
              end
            end
            S_BURST: begin
              state <= S_TAIL;
              cnt_q <= L_TAIL;
            end
            default: begin
              state  <= S_IDLE;
              done_q <= 1'b1;
            end
          endcase
        end
      end
    end
  end

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_on_finish_R11: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
  assert_start_taken_R11: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
  assert_lead_silent_R3: assert property (@(posedge clk) disable iff (rst)
    (state == S_LEAD) |-> !gate_out);
  assert_env_steady_R4: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$past(tick)) |-> $stable(gate_out));
  assert_bit_range_R6: assert property (@(posedge clk) disable iff (rst)
    bit_q <= 4'd8);

endmodule

// File: tb/sat_tone_msg_tx_tb.sv
module sat_tone_msg_tx_tb_top;
  localparam int D = 2;
  localparam int TS = 2, TL = 4, TLEAD = 6, TGAP = 5, TBUR = 7, TTAIL = 3;
  localparam int MAXB = 3;

  logic clk = 0, rst = 1, start = 0, cont_tone = 0;
  logic [23:0] msg_data = '0;
  logic [2:0] msg_len = '0;
  logic [1:0] burst_sel = '0;
  logic busy, done, gate_out, tone_out;

  int checks = 0, failures = 0;
  int exp_lv[0:255], exp_ln[0:255], exp_n;
  int act_lv[0:255], act_ln[0:255], act_n;

  always #2 clk = ~clk;

  sat_tone_msg_tx #(
    .CLK_HZ(8), .TICK_HZ(4), .TONE_HZ(2), .MAX_BYTES(MAXB), .LEN_W(3),
    .T_SHORT(TS), .T_LONG(TL), .T_LEAD(TLEAD), .T_GAP(TGAP),
    .T_BURST(TBUR), .T_TAIL(TTAIL)
  ) dut_i (
    .clk(clk), .rst(rst), .start(start), .msg_data(msg_data),
    .msg_len(msg_len), .burst_sel(burst_sel), .cont_tone(cont_tone),
    .busy(busy), .done(done), .gate_out(gate_out), .tone_out(tone_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic add_exp(input int lv, input int n);
    if (exp_n > 0 && exp_lv[exp_n-1] == lv) exp_ln[exp_n-1] += n;
    else begin exp_lv[exp_n] = lv; exp_ln[exp_n] = n; exp_n++; end
  endtask

  task automatic add_act(input int lv);
    if (act_n > 0 && act_lv[act_n-1] == lv) act_ln[act_n-1] += 1;
    else begin act_lv[act_n] = lv; act_ln[act_n] = 1; act_n++; end
  endtask

  task automatic add_bit(input bit v);
    add_exp(1, (v ? TS : TL) * D);
    add_exp(0, (v ? TL : TS) * D);
  endtask

  task automatic run(input logic [23:0] m, input int l, input logic [1:0] md,
                     input bit disturb, input string tag);
    int nb, cyc, bad_tone, mism;
    logic [7:0] b;
    exp_n = 0; act_n = 0;
    nb = (l > MAXB) ? MAXB : l;
    add_exp(0, TLEAD * D);
    for (int k = 0; k < nb; k++) begin
      b = m[8*k +: 8];
      for (int i = 7; i >= 0; i--) add_bit(b[i]);
      add_bit(~(^b));
    end
    add_exp(0, TGAP * D);
    if (md == 2'b01) begin
      add_exp(1, TBUR * D); add_exp(0, TTAIL * D);
    end else if (md == 2'b10) begin
      for (int i = 0; i < 9; i++) add_bit(1'b1);
      add_exp(0, TTAIL * D);
    end
    @(negedge clk);
    msg_data = m; msg_len = 3'(l); burst_sel = md; start = 1;
    @(negedge clk);
    start = 0;
    cyc = 0; bad_tone = 0;
    while (busy && cyc < 5000) begin
      add_act(gate_out);
      if (!gate_out && tone_out) bad_tone++;
      cyc++;
      if (disturb && cyc == 15) begin
        start = 1; msg_data = ~m; msg_len = 3'd1; burst_sel = 2'b01; cont_tone = 1;
      end
      if (disturb && cyc == 16) start = 0;
      @(negedge clk);
    end
    check(cyc < 5000, {tag, " R11 watchdog"}, cyc, 0);
    check(done === 1'b1, {tag, " R11 done at completion"}, done, 1);
    mism = (act_n != exp_n) ? 1 : 0;
    for (int i = 0; i < exp_n && i < act_n; i++)
      if (act_lv[i] != exp_lv[i] || act_ln[i] != exp_ln[i]) begin
        if (mism == 0)
          $display("FAIL %s R4/R5/R6/R7/R8/R9 segment %0d actual=%0d:%0d expected=%0d:%0d",
                   tag, i, act_lv[i], act_ln[i], exp_lv[i], exp_ln[i]);
        mism++;
      end
    check(mism == 0, {tag, " R4/R5/R6/R7/R8/R9 envelope"}, act_n, exp_n);
    if (nb > 0)
      check(act_lv[0] == 0 && act_ln[0] == TLEAD * D, {tag, " R3 lead-in"}, act_ln[0], TLEAD * D);
    check(bad_tone == 0, {tag, " R12 tone masked"}, bad_tone, 0);
    cont_tone = 0;
    @(negedge clk);
    check(done === 1'b0, {tag, " R11 done single cycle"}, done, 0);
  endtask

  initial begin
    #400000;
    failures++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic t[0:19];
    int bad;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(busy === 0 && done === 0 && gate_out === 0 && tone_out === 0,
          "R1 reset state", {busy, done, gate_out, tone_out}, 0);
    cont_tone = 1;
    @(negedge clk);
    check(gate_out === 1'b1, "R2 idle cont tone on", gate_out, 1);
    bad = 0;
    for (int k = 0; k < 20; k++) begin t[k] = tone_out; @(negedge clk); end
    for (int k = 2; k < 20; k++) if (t[k] == t[k-2]) bad++;
    check(bad == 0, "R12 carrier period", bad, 0);
    cont_tone = 0;
    @(negedge clk);
    check(gate_out === 1'b0, "R2 idle cont tone off", gate_out, 0);

    for (int v = 0; v < 256; v++) run({16'h0, 8'(v)}, 1, 2'b00, 0, "R5 sweep");
    run(24'hC3_5A_E1, 3, 2'b00, 0, "R5 three bytes");
    run(24'h00_12_80, 2, 2'b01, 0, "R8 tone burst");
    run(24'h00_00_39, 1, 2'b10, 0, "R8 data burst");
    run(24'h00_00_39, 1, 2'b11, 0, "R9 sel 11");
    run(24'hFF_00_7E, 3, 2'b10, 0, "R9 tail after data burst");
    for (int md = 0; md < 4; md++) run(24'hAB_CD_EF, 0, 2'(md), 0, "R10 zero length");
    run(24'h11_22_33, 5, 2'b00, 0, "R5 clamp 5");
    run(24'h44_55_66, 7, 2'b01, 0, "R5 clamp 7");
    run(24'h0F_F0_A5, 3, 2'b10, 1, "R11 R2 disturbed");
    run(24'h00_00_96, 1, 2'b00, 1, "R11 disturbed short");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule